// File: doc/BRIEF.md
# Cell-Stream Physical-Layer Link

This block sits between the cell side of a segmentation and reassembly engine and a physical-layer framer. On the transmit side it takes bytes from the engine through a valid/ready pair. It puts them on a registered byte bus with an enable and a start-of-cell flag. The start-of-cell flag marks byte 0 of every fixed-length cell. The framer may raise an early-warning full input, which pauses the stream. The pause can fall in the middle of a cell, and the stream picks up again at the byte where it stopped.

On the receive side, the framer presents a byte, a start-of-cell flag and an active-high empty input. A byte is taken only on a cycle where empty is low. The receiver first hunts for a start-of-cell byte. Once locked, it numbers each cell's bytes and flags the first and last byte. It reports two kinds of framing fault with a one-cycle error pulse: a start-of-cell flag that arrives early, and a missing start-of-cell flag. The framer's interrupt line is passed straight through to the host interrupt output.

The cell length and byte width are parameters. The defaults are 53 bytes of 8 bits.

Top module: `cell_phy_link`

## Requirements
- R1: Every accepted transmit byte whose position in the stream is a multiple of CELL_LEN (counting from 0 after reset) leaves with `tx_soc` high. All other bytes leave with `tx_soc` low, and `tx_soc` is never high without `tx_en`.
- R2: A transmit byte is accepted on a rising edge where `tx_in_valid` and `tx_in_ready` are both high. In the next cycle it appears on `tx_data` with `tx_en` high. `tx_en` is low in every cycle that follows an edge with no acceptance.
- R3: If `phy_full` is high at rising edge k, then `tx_in_ready` is low after edge k and `tx_en` is low after edge k+1. Both stay low for as long as `phy_full` is still sampled high. The worst-case reaction is two cycles, which is within the framer's four-cycle warning.
- R4: A pause caused by `phy_full` keeps the transmit byte position. The first byte sent after `phy_full` drops continues the cell at the index where it stopped, so the `tx_soc` spacing stays exactly CELL_LEN bytes.
- R5: A receive byte is taken only on an edge where `phy_rx_empty` is low. A byte taken at edge k is presented on `rx_data` with `rx_valid` high after edge k. While `phy_rx_empty` is high, both `rx_valid` and the receive flags ignore `phy_rx_soc` and `phy_rx_data`.
- R6: After reset, the receiver is hunting. It drops bytes that lack `phy_rx_soc`. A byte that carries `phy_rx_soc` is delivered with `rx_first` high and begins a locked cell.
- R7: While locked, the byte at cell index CELL_LEN-1 is delivered with `rx_last` high. The next byte is expected to carry `phy_rx_soc`.
- R8: While locked, a byte flagged `phy_rx_soc` at a cell index other than 0 restarts the count. It is delivered with `rx_first` high, and `rx_err` is high for that cycle.
- R9: While locked, a byte at cell index 0 without `phy_rx_soc` is dropped (`rx_valid` low), `rx_err` is high for one cycle, and the receiver returns to hunting.
- R10: `host_irq` equals `phy_irq` combinationally.
- R11: During reset, `tx_en`, `tx_soc`, `tx_in_ready`, `rx_valid`, `rx_first`, `rx_last` and `rx_err` are low. The transmit and receive byte positions restart at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, shared with the system bus |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_in_data | input | DATA_W | Transmit byte from the cell engine |
| tx_in_valid | input | 1 | Transmit byte present |
| tx_in_ready | output | 1 | Link can accept a transmit byte |
| phy_full | input | 1 | Framer early-warning full flag |
| tx_data | output | DATA_W | Byte to the framer |
| tx_soc | output | 1 | Marks byte 0 of a transmitted cell |
| tx_en | output | 1 | `tx_data` is valid this cycle |
| phy_rx_data | input | DATA_W | Byte from the framer |
| phy_rx_soc | input | 1 | Framer marks byte 0 of a received cell |
| phy_rx_empty | input | 1 | High: no receive byte this cycle |
| rx_data | output | DATA_W | Received byte to the cell engine |
| rx_valid | output | 1 | `rx_data` is valid this cycle |
| rx_first | output | 1 | Delivered byte is cell byte 0 |
| rx_last | output | 1 | Delivered byte is the final byte of the cell |
| rx_err | output | 1 | One-cycle framing fault pulse |
| phy_irq | input | 1 | Framer interrupt |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
A corrupted transmit byte position shows up as a shifted `tx_soc`. This is visible no later than the next cell boundary, CELL_LEN accepted bytes later. The bench counts every byte, so it catches a position lost across a full-flag pause. A wrong receive position or mode shows up within one cell: `rx_last` falls on the wrong byte, or `rx_err` fires (or stays silent) where the table says otherwise. A full flag sampled too late or ignored shows up as `tx_en` staying high more than two cycles after `phy_full` rises.

// File: rtl/cell_phy_pkg.sv
// Shared types for the cell-stream physical-layer link.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cell_phy_pkg;

    // Receive framing mode: searching for a start-of-cell byte, or counting a cell.
    typedef enum logic {
        RX_HUNT   = 1'b0,
        RX_LOCKED = 1'b1
    } rx_mode_e;

endpackage

// File: rtl/phy_tx_path.sv
// Transmit path: registers engine bytes toward the framer, flags byte 0 of
// every cell, and holds off while the framer reports full.
// Assumes: phy_full is synchronous to clk and gives >= 2 cycles of warning.
module phy_tx_path #(
    parameter int DATA_W   = 8,
    parameter int CELL_LEN = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              phy_full,
    output logic [DATA_W-1:0] out_data,
    output logic              out_soc,
    output logic              out_en
);
    localparam int IDX_W = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);

    logic             full_q;
    logic [IDX_W-1:0] idx;
    logic             take;

    assign in_ready = ~full_q;
    assign take     = in_valid & in_ready;

    // Sample the framer full flag; held asserted through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= 1'b1;
        else        full_q <= phy_full;
    end

    // Byte position inside the current cell; frozen while nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (take) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end

    // Output register toward the framer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            out_soc  <= 1'b0;
            out_data <= '0;
        end else begin
            out_en  <= take;
            out_soc <= take && (idx == '0);
            if (take) out_data <= in_data;
        end
    end

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phy_full |-> ##2 !out_en);
    p_soc_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_en);
    p_soc_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && idx == '0) |=> out_soc);
    p_resume_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(idx));
endmodule

// File: rtl/phy_rx_path.sv
// Receive path: takes framer bytes while empty is low, hunts for start of
// cell, numbers cell bytes and pulses an error on framing faults.
// Assumes: framer inputs are synchronous to clk.
module phy_rx_path
    import cell_phy_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CELL_LEN = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] phy_data,
    input  logic              phy_soc,
    input  logic              phy_empty,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_first,
    output logic              out_last,
    output logic              out_err
);
    localparam int IDX_W = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);

    rx_mode_e         mode, mode_n;
    logic [IDX_W-1:0] idx, idx_n, cur;
    logic             take, acc, first, err;

    assign take = ~phy_empty;

    // Framing decision for the byte on the inputs this cycle.
    always_comb begin
        mode_n = mode;
        idx_n  = idx;
        acc    = 1'b0;
        first  = 1'b0;
        err    = 1'b0;
        cur    = idx;
        if (take) begin
            if (phy_soc) begin
                acc    = 1'b1;
                first  = 1'b1;
                cur    = '0;
                err    = (mode == RX_LOCKED) && (idx != '0);
                mode_n = RX_LOCKED;
                idx_n  = (LAST_IDX == '0) ? '0 : IDX_W'(1);
            end else if (mode == RX_LOCKED) begin
                if (idx == '0) begin
                    err    = 1'b1;
                    mode_n = RX_HUNT;
                end else begin
                    acc   = 1'b1;
                    idx_n = (idx == LAST_IDX) ? '0 : idx + 1'b1;
                end
            end
        end
    end

    // Framing state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= RX_HUNT;
            idx  <= '0;
        end else begin
            mode <= mode_n;
            idx  <= idx_n;
        end
    end

    // Output register toward the cell engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= acc;
            out_first <= first;
            out_last  <= acc && (cur == LAST_IDX);
            out_err   <= err;
            if (acc) out_data <= phy_data;
        end
    end

    p_empty_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_empty |=> (!out_valid && !out_err));
    p_hunt_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RX_HUNT && take && !phy_soc) |=> !out_valid);
    p_first_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);
    p_last_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && idx == '0 && mode == RX_LOCKED));
    p_missing_soc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RX_LOCKED && take && !phy_soc && idx == '0) |=>
        (out_err && !out_valid && mode == RX_HUNT));
endmodule

// File: rtl/cell_phy_link.sv
// Top of the cell-stream physical-layer link: transmit path, receive path
// and interrupt pass-through.
// Assumes: all framer signals share clk with the system bus.
module cell_phy_link #(
    parameter int DATA_W   = 8,
    parameter int CELL_LEN = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_in_data,
    input  logic              tx_in_valid,
    output logic              tx_in_ready,
    input  logic              phy_full,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_soc,
    output logic              tx_en,
    input  logic [DATA_W-1:0] phy_rx_data,
    input  logic              phy_rx_soc,
    input  logic              phy_rx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              rx_last,
    output logic              rx_err,
    input  logic              phy_irq,
    output logic              host_irq
);
    // Framer interrupt reaches the host without a register (R10).
    assign host_irq = phy_irq;

    phy_tx_path #(.DATA_W(DATA_W), .CELL_LEN(CELL_LEN)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (tx_in_data),
        .in_valid (tx_in_valid),
        .in_ready (tx_in_ready),
        .phy_full (phy_full),
        .out_data (tx_data),
        .out_soc  (tx_soc),
        .out_en   (tx_en)
    );

    phy_rx_path #(.DATA_W(DATA_W), .CELL_LEN(CELL_LEN)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_data  (phy_rx_data),
        .phy_soc   (phy_rx_soc),
        .phy_empty (phy_rx_empty),
        .out_data  (rx_data),
        .out_valid (rx_valid),
        .out_first (rx_first),
        .out_last  (rx_last),
        .out_err   (rx_err)
    );
endmodule

// File: tb/cell_phy_link_tb_top.sv
module cell_phy_link_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CELL = 6;
    localparam int NRX = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_in_data = '0;
    logic       tx_in_valid = 1'b0;
    logic       tx_in_ready;
    logic       phy_full = 1'b0;
    logic [7:0] tx_data;
    logic       tx_soc, tx_en;
    logic [7:0] phy_rx_data = '0;
    logic       phy_rx_soc = 1'b0;
    logic       phy_rx_empty = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, rx_first, rx_last, rx_err;
    logic       phy_irq = 1'b0;
    logic       host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_phy_link #(.DATA_W(8), .CELL_LEN(CELL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
        .phy_full(phy_full), .tx_data(tx_data), .tx_soc(tx_soc), .tx_en(tx_en),
        .phy_rx_data(phy_rx_data), .phy_rx_soc(phy_rx_soc), .phy_rx_empty(phy_rx_empty),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_last(rx_last), .rx_err(rx_err),
        .phy_irq(phy_irq), .host_irq(host_irq)
    );

    // Receive vectors: {empty, soc, data, exp valid, exp first, exp last, exp err}
    localparam logic [13:0] RXV [0:NRX-1] = '{
        {1'b0, 1'b0, 8'hA0, 4'b0000},  // hunting, no soc: dropped (R6)
        {1'b1, 1'b1, 8'hA1, 4'b0000},  // empty high: soc ignored (R5)
        {1'b0, 1'b1, 8'h10, 4'b1100},  // lock on soc (R6)
        {1'b0, 1'b0, 8'h11, 4'b1000},
        {1'b1, 1'b0, 8'hEE, 4'b0000},  // gap (R5)
        {1'b0, 1'b0, 8'h12, 4'b1000},
        {1'b0, 1'b0, 8'h13, 4'b1000},
        {1'b0, 1'b0, 8'h14, 4'b1000},
        {1'b0, 1'b0, 8'h15, 4'b1010},  // index 5 is last (R7)
        {1'b0, 1'b1, 8'h20, 4'b1100},
        {1'b0, 1'b0, 8'h21, 4'b1000},
        {1'b0, 1'b1, 8'h30, 4'b1101},  // early soc: restart + error (R8)
        {1'b0, 1'b0, 8'h31, 4'b1000},
        {1'b0, 1'b0, 8'h32, 4'b1000},
        {1'b0, 1'b0, 8'h33, 4'b1000},
        {1'b0, 1'b0, 8'h34, 4'b1000},
        {1'b0, 1'b0, 8'h35, 4'b1010},  // last after restart (R7, R8)
        {1'b0, 1'b0, 8'h40, 4'b0001},  // missing soc: drop + error (R9)
        {1'b0, 1'b0, 8'h41, 4'b0000},  // back in hunt (R9)
        {1'b0, 1'b1, 8'h50, 4'b1100}   // relock
    };

    // Record one check; print a failure line on mismatch.
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare receive outputs with one vector's expectations.
    task automatic rx_check(input int i);
        logic [13:0] v;
        v = RXV[i];
        chk(rx_valid == v[3], "R5 rx_valid", 32'(rx_valid), 32'(v[3]));
        chk(rx_first == v[2], "R6 R8 rx_first", 32'(rx_first), 32'(v[2]));
        chk(rx_last == v[1], "R7 rx_last", 32'(rx_last), 32'(v[1]));
        chk(rx_err == v[0], "R8 R9 rx_err", 32'(rx_err), 32'(v[0]));
        if (v[3]) chk(rx_data == v[11:4], "R5 rx_data", 32'(rx_data), 32'(v[11:4]));
    endtask

    int  drv_seq = 0;
    int  mon_seq = 0;
    int  soc_cnt = 0;
    bit  drv_on = 1'b0;
    bit  prev_acc = 1'b0;

    // One transmit cycle: check outputs from the last edge, then drive.
    task automatic tx_step();
        @(negedge clk);
        chk(tx_en == prev_acc, "R2 tx_en latency", 32'(tx_en), 32'(prev_acc));
        if (tx_en) begin
            chk(tx_data == 8'(mon_seq), "R2 tx_data", 32'(tx_data), 32'(mon_seq & 8'hFF));
            chk(tx_soc == ((mon_seq % CELL) == 0), "R1 R4 tx_soc", 32'(tx_soc),
                32'((mon_seq % CELL) == 0));
            if (tx_soc) soc_cnt++;
            mon_seq++;
        end else begin
            chk(tx_soc == 1'b0, "R1 soc without enable", 32'(tx_soc), 32'd0);
        end
        tx_in_valid = drv_on;
        tx_in_data  = 8'(drv_seq);
        prev_acc    = drv_on && tx_in_ready;
        if (prev_acc) drv_seq++;
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_en == 0, "R11 tx_en", 32'(tx_en), 0);
        chk(tx_soc == 0, "R11 tx_soc", 32'(tx_soc), 0);
        chk(tx_in_ready == 0, "R11 tx_in_ready", 32'(tx_in_ready), 0);
        chk(rx_valid == 0, "R11 rx_valid", 32'(rx_valid), 0);
        chk(rx_err == 0 && rx_first == 0 && rx_last == 0, "R11 rx flags",
            {29'd0, rx_err, rx_first, rx_last}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_in_ready == 1, "R3 ready after reset", 32'(tx_in_ready), 1);

        // Receive table walk
        for (int i = 0; i < NRX; i++) begin
            @(negedge clk);
            if (i > 0) rx_check(i - 1);
            {phy_rx_empty, phy_rx_soc, phy_rx_data} = RXV[i][13:4];
        end
        @(negedge clk);
        rx_check(NRX - 1);
        phy_rx_empty = 1'b1;
        phy_rx_soc   = 1'b0;

        // R10: interrupt pass-through
        phy_irq = 1'b1; #1;
        chk(host_irq == 1, "R10 host_irq high", 32'(host_irq), 1);
        phy_irq = 1'b0; #1;
        chk(host_irq == 0, "R10 host_irq low", 32'(host_irq), 0);

        // Transmit: continuous stream, then a mid-cell pause
        drv_on = 1'b1;
        repeat (8) tx_step();
        phy_full = 1'b1;
        tx_step();
        chk(tx_in_ready == 0, "R3 ready drops", 32'(tx_in_ready), 0);
        for (int k = 0; k < 5; k++) begin
            tx_step();
            chk(tx_en == 0, "R3 tx_en held off", 32'(tx_en), 0);
            chk(tx_in_ready == 0, "R3 ready held off", 32'(tx_in_ready), 0);
        end
        phy_full = 1'b0;
        repeat (14) tx_step();
        drv_on = 1'b0;
        repeat (3) tx_step();
        chk(mon_seq == drv_seq, "R2 bytes delivered", 32'(mon_seq), 32'(drv_seq));
        chk(soc_cnt == (mon_seq + CELL - 1) / CELL, "R1 R4 soc count",
            32'(soc_cnt), 32'((mon_seq + CELL - 1) / CELL));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule